// File: doc/BRIEF.md
# Clause 45 MDIO Indirect Access Sequencer

This block turns one host register access into the two management-bus cycles that a Clause 45 device expects. First comes an address cycle that carries the 16-bit register number, the 5-bit device type and the 5-bit port address. Then comes the read or write cycle that moves the data. The host side is a plain valid/acknowledge request port with single-cycle done and error responses. The other side drives a bit-level frame shifter through a command word, a command strobe, a write-data strobe, a busy flag and the shifter's data register.

Before it touches the bus, the sequencer takes a per-port ownership lock. The lock is selected by a port-identity status bit. A refused lock ends the access at once. In each phase the busy flag is polled once per programmable interval, and the number of polls is bounded. A phase that stays busy past its last poll ends the access with an error that names the phase, and the data phase is never started after a failed address phase. Whenever the lock was taken, it is handed back in the response cycle.

Top module: `mdio_c45_seq`

## Requirements
- R1: A request is acknowledged (`reqAck` high for one cycle) only while the sequencer is idle. A request held high during an access is not acknowledged again until the response has been given.
- R2: Every granted access issues an address command (opcode 2'b00) before its data command. The data command uses opcode 2'b01 for a write and 2'b11 for a read, and it is issued only if the address phase completed.
- R3: For a write, `dataWrStrobe` presents the 16-bit write data exactly once, in the cycle just before the address command. A read produces no write-data strobe.
- R4: After a command is issued in cycle T, `phyBusy` is sampled in cycles T+k*POLL_INTERVAL (k = 1, 2, ...). The phase completes at the first sample that sees `phyBusy` low, and the next step starts in the following cycle.
- R5: If `phyBusy` is still high at sample MAX_POLLS, the access ends with error code 2 (address phase) or 3 (data phase). After an address-phase failure, no data command is issued.
- R6: A successful read returns bits [RD_SHIFT+15:RD_SHIFT] of `phyDataReg`, sampled at the poll that completes the data phase, on `rspRdData` during the response cycle.
- R7: In the cycle after acknowledge, `lockTry` is raised with `lockSel` equal to the `portIdSel` captured at acknowledge. If `lockGrant` is low in that cycle, the access ends with error code 1, issues no command and does not release the lock.
- R8: When the lock was granted, `lockRelease` pulses once, in the response cycle, whatever the outcome.
- R9: The response is a single-cycle pulse of either `rspDone` (error code 0) or `rspError` (codes 1 to 3), never both. `rspErrCode` is valid in that cycle.
- R10: The command word places the register address at bits [15:0], the device type at [20:16], the port address at [25:21] and the opcode at [27:26], sets the start bit 30 and holds zero elsewhere (default field parameters).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host requests an access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRegAddr | input | 16 | Target register number |
| reqDevType | input | 5 | Target device type |
| reqPortAddr | input | 5 | Target port address |
| reqWrData | input | 16 | Data for a write |
| reqAck | output | 1 | Request accepted this cycle |
| rspDone | output | 1 | Access finished without error |
| rspError | output | 1 | Access finished with an error |
| rspErrCode | output | 2 | 0 none, 1 lock refused, 2 address timeout, 3 data timeout |
| rspRdData | output | 16 | Read result, valid with `rspDone` |
| portIdSel | input | 1 | Port-identity status bit that selects the lock |
| lockTry | output | 1 | Attempt to take the ownership lock |
| lockSel | output | 1 | Which port's lock is addressed |
| lockGrant | input | 1 | Lock granted (same cycle as `lockTry`) |
| lockRelease | output | 1 | Return the lock |
| cmdStrobe | output | 1 | Command word valid, start a frame |
| cmdWord | output | 32 | Packed command for the frame shifter |
| dataWrStrobe | output | 1 | Load write data into the shifter's data register |
| dataWrValue | output | 16 | Write data to load |
| phyBusy | input | 1 | Shifter is still running the last command |
| phyDataReg | input | 32 | Shifter data register, read result in the upper field |

## Verification
The embedded assertions check on every cycle that a data command is always preceded by an address command of the same access, that the write-data load is followed at once by an address command, that no command or release is issued without a held lock, that acknowledges never come back to back, and that done and error are exclusive single-cycle pulses. The poll timing, the exact boundary between the last successful poll and a timeout, the skipped data phase, the packed field values, the selected lock and the returned read field can only be shown by the bench. It drives a behavioural shifter whose busy time is chosen per phase, and it measures the response latency and the command log against values worked out from the poll arithmetic.

// File: rtl/mdio_seq_pkg.sv
package mdio_seq_pkg;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_LOCK     = 2'd1,
    ERR_ADDR_TMO = 2'd2,
    ERR_DATA_TMO = 2'd3
  } errCode_t;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b11
  } mdioOp_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic     capture;    // latch request fields
    logic     issueCmd;   // command goes out, restart timers
    logic     dataPhase;  // command is the data-phase one
    logic     waitTick;   // advance the poll interval timer
    logic     pollFail;   // a poll saw busy, count it
    logic     grabRead;   // capture read field
    logic     setErr;     // record error code
    errCode_t errVal;
  } seqCtl_t;

endpackage

// File: rtl/mdio_seq_dp.sv
module mdio_seq_dp
  import mdio_seq_pkg::*;
#(
  parameter int CMD_W         = 32,
  parameter int REG_LSB       = 0,
  parameter int DEV_LSB       = 16,
  parameter int PORT_LSB      = 21,
  parameter int OP_LSB        = 26,
  parameter int START_BIT     = 30,
  parameter int RD_REG_W      = 32,
  parameter int RD_SHIFT      = 16,
  parameter int POLL_INTERVAL = 500,
  parameter int MAX_POLLS     = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtl_t             ctl,
  input  logic                reqWrite,
  input  logic [15:0]         reqRegAddr,
  input  logic [4:0]          reqDevType,
  input  logic [4:0]          reqPortAddr,
  input  logic [15:0]         reqWrData,
  input  logic                portIdSel,
  input  logic [RD_REG_W-1:0] phyDataReg,
  output logic                isWrite,
  output logic                lockSel,
  output logic                intervalDone,
  output logic                lastPoll,
  output logic [CMD_W-1:0]    cmdWord,
  output logic [15:0]         wrData,
  output logic [15:0]         rdData,
  output errCode_t            errCode
);

  localparam int DATA_W = 16;
  localparam int TMR_W  = (POLL_INTERVAL > 1) ? $clog2(POLL_INTERVAL) : 1;
  localparam int POLL_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [TMR_W-1:0]  TMR_LAST  = TMR_W'(POLL_INTERVAL - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);

  logic [15:0]       regAddrQ;
  logic [4:0]        devTypeQ;
  logic [4:0]        portAddrQ;
  logic              writeQ;
  logic              portSelQ;
  logic [15:0]       wrDataQ;
  logic [DATA_W-1:0] rdDataQ;
  errCode_t          errQ;
  logic [TMR_W-1:0]  tmrCnt;
  logic [POLL_W-1:0] pollCnt;
  mdioOp_t           curOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regAddrQ  <= '0;
      devTypeQ  <= '0;
      portAddrQ <= '0;
      writeQ    <= 1'b0;
      portSelQ  <= 1'b0;
      wrDataQ   <= '0;
    end else if (ctl.capture) begin
      regAddrQ  <= reqRegAddr;
      devTypeQ  <= reqDevType;
      portAddrQ <= reqPortAddr;
      writeQ    <= reqWrite;
      portSelQ  <= portIdSel;
      wrDataQ   <= reqWrData;
    end
  end

  // interval timer and poll counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt  <= '0;
      pollCnt <= '0;
    end else if (ctl.issueCmd) begin
      tmrCnt  <= '0;
      pollCnt <= '0;
    end else begin
      if (ctl.waitTick) tmrCnt <= intervalDone ? '0 : tmrCnt + 1'b1;
      if (ctl.pollFail) pollCnt <= pollCnt + 1'b1;
    end
  end

  assign intervalDone = (tmrCnt == TMR_LAST);
  assign lastPoll     = (pollCnt == POLL_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ    <= ERR_NONE;
      rdDataQ <= '0;
    end else begin
      if (ctl.capture)     errQ <= ERR_NONE;
      else if (ctl.setErr) errQ <= ctl.errVal;
      if (ctl.grabRead)    rdDataQ <= DATA_W'(phyDataReg >> RD_SHIFT);
    end
  end

  always_comb begin
    if (!ctl.dataPhase) curOp = OP_ADDR;
    else if (writeQ)    curOp = OP_WRITE;
    else                curOp = OP_READ;
  end

  always_comb begin
    cmdWord                  = '0;
    cmdWord[REG_LSB +: 16]   = regAddrQ;
    cmdWord[DEV_LSB +: 5]    = devTypeQ;
    cmdWord[PORT_LSB +: 5]   = portAddrQ;
    cmdWord[OP_LSB +: 2]     = curOp;
    cmdWord[START_BIT]       = 1'b1;
  end

  assign isWrite = writeQ;
  assign lockSel = portSelQ;
  assign wrData  = wrDataQ;
  assign rdData  = rdDataQ;
  assign errCode = errQ;

  // R5: the poll counter never passes its last value while polling
  assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pollFail |-> !lastPoll);

endmodule

// File: rtl/mdio_seq_ctl.sv
module mdio_seq_ctl
  import mdio_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     isWrite,
  input  logic     lockGrant,
  input  logic     phyBusy,
  input  logic     intervalDone,
  input  logic     lastPoll,
  input  errCode_t errCode,
  output seqCtl_t  ctl,
  output logic     reqAck,
  output logic     lockTry,
  output logic     lockRelease,
  output logic     cmdStrobe,
  output logic     dataWrStrobe,
  output logic     rspDone,
  output logic     rspError
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOCK, S_LOAD, S_ADDR, S_ADDR_WAIT, S_DATA, S_DATA_WAIT, S_FINISH
  } seqState_t;

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState    = state;
    ctl          = '0;
    reqAck       = 1'b0;
    lockTry      = 1'b0;
    lockRelease  = 1'b0;
    cmdStrobe    = 1'b0;
    dataWrStrobe = 1'b0;
    rspDone      = 1'b0;
    rspError     = 1'b0;
    unique case (state)
      S_IDLE: if (reqValid) begin
        reqAck      = 1'b1;
        ctl.capture = 1'b1;
        nextState   = S_LOCK;
      end
      S_LOCK: begin
        lockTry = 1'b1;
        if (lockGrant) nextState = isWrite ? S_LOAD : S_ADDR;
        else begin
          ctl.setErr = 1'b1;
          ctl.errVal = ERR_LOCK;
          nextState  = S_FINISH;
        end
      end
      S_LOAD: begin
        dataWrStrobe = 1'b1;
        nextState    = S_ADDR;
      end
      S_ADDR: begin
        cmdStrobe    = 1'b1;
        ctl.issueCmd = 1'b1;
        nextState    = S_ADDR_WAIT;
      end
      S_ADDR_WAIT: begin
        ctl.waitTick = 1'b1;
        if (intervalDone) begin
          if (!phyBusy) nextState = S_DATA;
          else if (lastPoll) begin
            ctl.setErr = 1'b1;
            ctl.errVal = ERR_ADDR_TMO;
            nextState  = S_FINISH;
          end else ctl.pollFail = 1'b1;
        end
      end
      S_DATA: begin
        cmdStrobe     = 1'b1;
        ctl.issueCmd  = 1'b1;
        ctl.dataPhase = 1'b1;
        nextState     = S_DATA_WAIT;
      end
      S_DATA_WAIT: begin
        ctl.waitTick = 1'b1;
        if (intervalDone) begin
          if (!phyBusy) begin
            ctl.grabRead = !isWrite;
            nextState    = S_FINISH;
          end else if (lastPoll) begin
            ctl.setErr = 1'b1;
            ctl.errVal = ERR_DATA_TMO;
            nextState  = S_FINISH;
          end else ctl.pollFail = 1'b1;
        end
      end
      S_FINISH: begin
        rspDone     = (errCode == ERR_NONE);
        rspError    = (errCode != ERR_NONE);
        lockRelease = (errCode != ERR_LOCK);
        nextState   = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  // R1: acknowledge never repeats on consecutive cycles
  assert_ack_gap_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R9: done and error are exclusive
  assert_rsp_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(rspDone && rspError));

  // R9: a response lasts one cycle
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspDone || rspError) |=> !(rspDone || rspError));

  // R8: release only together with the response
  assert_release_with_rsp_R8: assert property (@(posedge clk) disable iff (!rstN)
    lockRelease |-> (rspDone || rspError));

endmodule

// File: rtl/mdio_c45_seq.sv
module mdio_c45_seq
  import mdio_seq_pkg::*;
#(
  parameter int CMD_W         = 32,
  parameter int REG_LSB       = 0,
  parameter int DEV_LSB       = 16,
  parameter int PORT_LSB      = 21,
  parameter int OP_LSB        = 26,
  parameter int START_BIT     = 30,
  parameter int RD_REG_W      = 32,
  parameter int RD_SHIFT      = 16,
  parameter int POLL_INTERVAL = 500,
  parameter int MAX_POLLS     = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [15:0]         reqRegAddr,
  input  logic [4:0]          reqDevType,
  input  logic [4:0]          reqPortAddr,
  input  logic [15:0]         reqWrData,
  output logic                reqAck,
  output logic                rspDone,
  output logic                rspError,
  output logic [1:0]          rspErrCode,
  output logic [15:0]         rspRdData,
  input  logic                portIdSel,
  output logic                lockTry,
  output logic                lockSel,
  input  logic                lockGrant,
  output logic                lockRelease,
  output logic                cmdStrobe,
  output logic [CMD_W-1:0]    cmdWord,
  output logic                dataWrStrobe,
  output logic [15:0]         dataWrValue,
  input  logic                phyBusy,
  input  logic [RD_REG_W-1:0] phyDataReg
);

  seqCtl_t  ctl;
  errCode_t errCode;
  logic     isWrite;
  logic     intervalDone;
  logic     lastPoll;

  mdio_seq_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .isWrite      (isWrite),
    .lockGrant    (lockGrant),
    .phyBusy      (phyBusy),
    .intervalDone (intervalDone),
    .lastPoll     (lastPoll),
    .errCode      (errCode),
    .ctl          (ctl),
    .reqAck       (reqAck),
    .lockTry      (lockTry),
    .lockRelease  (lockRelease),
    .cmdStrobe    (cmdStrobe),
    .dataWrStrobe (dataWrStrobe),
    .rspDone      (rspDone),
    .rspError     (rspError)
  );

  mdio_seq_dp #(
    .CMD_W         (CMD_W),
    .REG_LSB       (REG_LSB),
    .DEV_LSB       (DEV_LSB),
    .PORT_LSB      (PORT_LSB),
    .OP_LSB        (OP_LSB),
    .START_BIT     (START_BIT),
    .RD_REG_W      (RD_REG_W),
    .RD_SHIFT      (RD_SHIFT),
    .POLL_INTERVAL (POLL_INTERVAL),
    .MAX_POLLS     (MAX_POLLS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .reqWrite     (reqWrite),
    .reqRegAddr   (reqRegAddr),
    .reqDevType   (reqDevType),
    .reqPortAddr  (reqPortAddr),
    .reqWrData    (reqWrData),
    .portIdSel    (portIdSel),
    .phyDataReg   (phyDataReg),
    .isWrite      (isWrite),
    .lockSel      (lockSel),
    .intervalDone (intervalDone),
    .lastPoll     (lastPoll),
    .cmdWord      (cmdWord),
    .wrData       (dataWrValue),
    .rdData       (rspRdData),
    .errCode      (errCode)
  );

  assign rspErrCode = errCode;

  // ordering trackers for the assertions below
  logic addrPending;
  logic lockHeld;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPending <= 1'b0;
      lockHeld    <= 1'b0;
    end else begin
      if (cmdStrobe) addrPending <= (cmdWord[OP_LSB +: 2] == OP_ADDR);
      else if (rspDone || rspError) addrPending <= 1'b0;
      if (lockTry && lockGrant) lockHeld <= 1'b1;
      else if (lockRelease)     lockHeld <= 1'b0;
    end
  end

  // R2: a data command follows an address command of the same access
  assert_addr_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && cmdWord[OP_LSB +: 2] != OP_ADDR) |-> addrPending);

  // R3: write data load is followed at once by the address command
  assert_wrdata_lead_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataWrStrobe |=> (cmdStrobe && cmdWord[OP_LSB +: 2] == OP_ADDR));

  // R7: no bus command without the lock
  assert_cmd_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> lockHeld);

  // R8: the lock is only returned when held
  assert_release_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    lockRelease |-> lockHeld);

endmodule

// File: tb/mdio_c45_seq_tb.sv
module mdio_c45_seq_tb;

  localparam int PI = 4;
  localparam int MP = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqRegAddr = '0, reqWrData = '0;
  logic [4:0]  reqDevType = '0, reqPortAddr = '0;
  logic        reqAck, rspDone, rspError;
  logic [1:0]  rspErrCode;
  logic [15:0] rspRdData;
  logic        portIdSel = 1'b0, lockTry, lockSel, lockGrant = 1'b0, lockRelease;
  logic        cmdStrobe, dataWrStrobe, phyBusy;
  logic [31:0] cmdWord, phyDataReg = '0;
  logic [15:0] dataWrValue;

  always #10 clk = ~clk;

  mdio_c45_seq #(.POLL_INTERVAL(PI), .MAX_POLLS(MP)) u_dut (.*);

  int nChk = 0, nFail = 0;

  // behavioural frame shifter and event monitor
  int          aLenCur = 0, dLenCur = 0, remaining = 0;
  int          cmdTotal = 0, dwTotal = 0, dwAtCmd = 0, tryTotal = 0, relTotal = 0;
  logic [31:0] cmdHist [8];
  logic [15:0] dwVal = '0;
  logic        lastLockSel = 1'b0;
  assign phyBusy = (remaining != 0);

  always @(posedge clk) begin
    if (cmdStrobe) begin
      cmdHist[cmdTotal % 8] <= cmdWord;
      cmdTotal  <= cmdTotal + 1;
      remaining <= (cmdWord[27:26] == 2'b00) ? aLenCur : dLenCur;
    end else if (remaining != 0) remaining <= remaining - 1;
    if (dataWrStrobe) begin
      dwTotal <= dwTotal + 1; dwVal <= dataWrValue; dwAtCmd <= cmdTotal;
    end
    if (lockTry) begin tryTotal <= tryTotal + 1; lastLockSel <= lockSel; end
    if (lockRelease) relTotal <= relTotal + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input logic [15:0] r, input logic [4:0] d,
                                        input logic [4:0] p, input logic [1:0] op);
    return {1'b0, 1'b1, 2'b00, op, p, d, r} & 32'h4FFF_FFFF | (32'(op) << 26);
  endfunction

  function automatic int pollsTo(input int len);
    return len / PI + 1;
  endfunction

  task automatic doTxn(input bit w, input logic [15:0] ra, input logic [4:0] dv,
                       input logic [4:0] pa, input logic [15:0] wd, input bit pid,
                       input bit grant, input int aLen, input int dLen,
                       input logic [15:0] rdv, input int hold);
    int expErr, expCmds, expFin, ka, kd, base, dwBase, tryBase, relBase, cnt, acks;
    bit seen;
    logic [1:0] gotCode; logic gotDone, gotErr; logic [15:0] gotRd;
    ka = pollsTo(aLen); kd = pollsTo(dLen);
    if (!grant)       begin expErr = 1; expCmds = 0; expFin = 2; end
    else if (ka > MP) begin expErr = 2; expCmds = 1; expFin = 3 + int'(w) + MP*PI; end
    else if (kd > MP) begin expErr = 3; expCmds = 2; expFin = 4 + int'(w) + (ka+MP)*PI; end
    else              begin expErr = 0; expCmds = 2; expFin = 4 + int'(w) + (ka+kd)*PI; end
    @(negedge clk);
    base = cmdTotal; dwBase = dwTotal; tryBase = tryTotal; relBase = relTotal;
    aLenCur = aLen; dLenCur = dLen; lockGrant = grant;
    phyDataReg = {rdv, 16'($urandom)};
    reqWrite = w; reqRegAddr = ra; reqDevType = dv; reqPortAddr = pa;
    reqWrData = wd; portIdSel = pid; reqValid = 1'b1;
    #1 chk(reqAck === 1'b1, "R1", "ack when idle", reqAck, 1);
    cnt = 0; seen = 0; acks = 0;
    gotCode = '0; gotDone = 0; gotErr = 0; gotRd = '0;
    while (!seen && cnt < 2000) begin
      @(negedge clk); cnt++;
      if (reqValid && reqAck) acks++;
      if (cnt >= hold) reqValid = 1'b0;
      if (rspDone || rspError) begin
        seen = 1; gotCode = rspErrCode; gotDone = rspDone; gotErr = rspError; gotRd = rspRdData;
      end
    end
    reqValid = 1'b0;
    chk(seen, "R4", "response seen", seen, 1);
    @(posedge clk); #1;
    chk(acks == 0, "R1", "no re-ack while busy", acks, 0);
    chk(cnt == expFin, "R4", "response latency", cnt, expFin);
    chk(gotCode == 2'(expErr), expErr == 1 ? "R7" : "R5", "error code", gotCode, expErr);
    chk(gotDone == (expErr == 0) && gotErr == (expErr != 0), "R9", "done/error",
        {gotDone, gotErr}, {expErr == 0, expErr != 0});
    chk(cmdTotal - base == expCmds, "R5", "command count", cmdTotal - base, expCmds);
    chk(tryTotal - tryBase == 1 && lastLockSel == pid, "R7", "lock try/select",
        lastLockSel, pid);
    chk(relTotal - relBase == int'(grant), "R8", "release count", relTotal - relBase, grant);
    if (expCmds >= 1)
      chk(cmdHist[base % 8] == mkCmd(ra, dv, pa, 2'b00), "R10", "address command",
          cmdHist[base % 8], mkCmd(ra, dv, pa, 2'b00));
    if (expCmds == 2)
      chk(cmdHist[(base+1) % 8] == mkCmd(ra, dv, pa, w ? 2'b01 : 2'b11), "R2",
          "data command", cmdHist[(base+1) % 8], mkCmd(ra, dv, pa, w ? 2'b01 : 2'b11));
    if (w && grant) begin
      chk(dwTotal - dwBase == 1 && dwVal == wd, "R3", "write data load", dwVal, wd);
      chk(dwAtCmd == base, "R3", "load before address", dwAtCmd, base);
    end else
      chk(dwTotal == dwBase, "R3", "no data load", dwTotal - dwBase, 0);
    if (!w && expErr == 0) chk(gotRd == rdv, "R6", "read field", gotRd, rdv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk(rspDone === 0 && rspError === 0, "R9", "reset response", {rspDone, rspError}, 0);
    chk(cmdStrobe === 0 && lockTry === 0 && dataWrStrobe === 0, "R2", "reset idle bus",
        {cmdStrobe, lockTry, dataWrStrobe}, 0);
    // directed corners
    doTxn(0, 16'hC001, 5'd1, 5'd3, 16'h0, 0, 1, 0, 0, 16'hBEEF, 1);
    doTxn(1, 16'h0000, 5'd30, 5'd31, 16'h1234, 1, 1, 0, 0, 16'h0, 1);
    doTxn(0, 16'hFFFF, 5'd7, 5'd0, 16'h0, 0, 1, MP*PI-1, MP*PI-1, 16'h5A5A, 1);
    doTxn(0, 16'h0010, 5'd3, 5'd9, 16'h0, 1, 1, MP*PI, 0, 16'h1111, 1);
    doTxn(1, 16'h0020, 5'd4, 5'd2, 16'hA5A5, 0, 1, 3, MP*PI, 16'h0, 1);
    doTxn(1, 16'h0030, 5'd5, 5'd1, 16'h7777, 1, 0, 0, 0, 16'h0, 1);
    doTxn(0, 16'h0040, 5'd1, 5'd1, 16'h0, 0, 1, 5, 9, 16'h8001, 5);
    // constrained random
    for (int i = 0; i < 60; i++) begin
      doTxn(1'($urandom), 16'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
            1'($urandom), ($urandom % 8) != 0, int'($urandom % (MP*PI+3)),
            int'($urandom % (MP*PI+3)), 16'($urandom), 1 + int'($urandom % 3));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule